// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block takes a serial line that is not aligned to the local clock and turns each frame into a data word. It oversamples the line on an enable tick that runs at sixteen times the bit rate. It validates a start bit at mid-bit, then samples the data bits, an optional parity bit and one or two stop bits, each at its centre. The finished word goes into a holding register.

Four sticky flags report the state of that register and the quality of the frames: data-ready, lost-word, bad-parity and bad-stop. A receive interrupt request goes high when the interrupt enable is set and any flag is up. Software clears the error flags with a strobe. It empties the holding register with a read strobe. A pulse from an external bus-break detector wipes all four flags together. The bit-rate tick and break detection are generated outside the block.

Top module: `serial_rx_flags`

## Requirements
- R1: After synchronous reset, all four flags, the held word and the interrupt request are 0.
- R2: With `msb_first` at 0, the first data bit on the line lands in bit 0 of the word. With `msb_first` at 1, the first data bit lands in the top bit.
- R3: While `sync_mode` is 1, assembly is LSB-first whatever `msb_first` holds.
- R4: A start is recognised only on a high-to-low line transition that is still low at mid-bit, eight ticks later. A low pulse shorter than that is ignored and loads nothing.
- R5: With `par_en` at 1, one even-parity bit follows the data, and a mismatch sets `flag_par`. With `par_en` at 0, no parity bit is expected and `flag_par` never sets.
- R6: A low sample on a stop bit sets `flag_stop`. With `two_stop` at 1, a low first or a low second stop bit sets the same flag.
- R7: `flag_ready` sets when a word is loaded. Among the strobes, only `rd_stb` clears it; `clr_err` leaves it alone.
- R8: If a frame completes while `flag_ready` is 1 and no read happens in that cycle, `flag_lost` sets and the held word keeps its old value.
- R9: `clr_err` clears `flag_par`, `flag_lost` and `flag_stop`, and it wins over an error set in the same cycle.
- R10: `brk_det` clears all four flags at once and wins over any set in the same cycle.
- R11: `irq` is 1 exactly when `rie` is 1 and at least one of the four flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line |
| par_en | input | 1 | Expect an even-parity bit |
| two_stop | input | 1 | Expect two stop bits |
| msb_first | input | 1 | Assemble MSB-first when 1 |
| sync_mode | input | 1 | Forces LSB-first assembly when 1 |
| clr_err | input | 1 | Clear the error flags |
| rd_stb | input | 1 | Read of the held word |
| brk_det | input | 1 | Bus-break detected pulse |
| rie | input | 1 | Receive interrupt enable |
| rdata | output | DW | Held received word |
| flag_par | output | 1 | Parity error flag |
| flag_lost | output | 1 | Overrun flag |
| flag_stop | output | 1 | Framing error flag |
| flag_ready | output | 1 | Receive data full flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest cases to reach are the same-cycle priorities, where a clear lands in exactly the cycle a frame completes. From the ports, the completion edge sits behind the synchroniser and the mid-bit counter. The bench therefore holds `clr_err` or `brk_det` high for the whole length of a frame that carries an error, so the clear is certain to overlap the set. Overrun is reached by sending two frames back to back with no read in between, and then checking that the first word is still held.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int OSR = 16;
    localparam int MID = OSR / 2 - 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
    } rx_state_t;

    typedef struct packed {
        logic par;
        logic lost;
        logic stop;
        logic ready;
    } rx_flags_t;

    function automatic logic any_flag(input rx_flags_t f);
        return f.par | f.lost | f.stop | f.ready;
    endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rx,
    input  logic          par_en,
    input  logic          two_stop,
    input  logic          msb,
    output logic [DW-1:0] word,
    output logic          par_bad,
    output logic          stop_bad,
    output logic          done
);
    localparam int CW = $clog2(OSR);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic          par_acc;
    logic          rx_prev;
    logic          at_mid;
    logic          at_end;

    assign at_mid = (cnt == CW'(MID));
    assign at_end = (cnt == CW'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            word     <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            done     <= 1'b0;
            rx_prev  <= 1'b1;
        end else begin
            done <= 1'b0;
            if (tick) begin
                rx_prev <= rx;
                case (st)
                    ST_IDLE: begin
                        if (!rx && rx_prev) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            if (!rx) begin
                                st       <= ST_DATA;
                                bidx     <= '0;
                                par_acc  <= 1'b0;
                                par_bad  <= 1'b0;
                                stop_bad <= 1'b0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_end) begin
                            cnt     <= '0;
                            par_acc <= par_acc ^ rx;
                            if (msb) word <= {word[DW-2:0], rx};
                            else     word <= {rx, word[DW-1:1]};
                            if (bidx == BW'(DW - 1)) st <= par_en ? ST_PAR : ST_STOP1;
                            else                     bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_end) begin
                            cnt     <= '0;
                            par_bad <= par_acc ^ rx;
                            st      <= ST_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (at_end) begin
                            cnt <= '0;
                            if (!rx) stop_bad <= 1'b1;
                            if (two_stop) begin
                                st <= ST_STOP2;
                            end else begin
                                st   <= ST_IDLE;
                                done <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (at_end) begin
                            cnt  <= '0;
                            if (!rx) stop_bad <= 1'b1;
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [DW-1:0] word,
    input  logic          par_bad,
    input  logic          stop_bad,
    input  logic          clr_err,
    input  logic          rd_stb,
    input  logic          brk_det,
    output logic [DW-1:0] hold,
    output rx_flags_t     flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            flags <= '0;
        end else if (brk_det) begin
            flags <= '0;
        end else begin
            if (rd_stb) flags.ready <= 1'b0;
            if (done) begin
                if (flags.ready && !rd_stb) begin
                    flags.lost <= 1'b1;
                end else begin
                    hold        <= word;
                    flags.ready <= 1'b1;
                end
                if (par_bad)  flags.par  <= 1'b1;
                if (stop_bad) flags.stop <= 1'b1;
            end
            if (clr_err) begin
                flags.par  <= 1'b0;
                flags.lost <= 1'b0;
                flags.stop <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
    import srx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          par_en,
    input  logic          two_stop,
    input  logic          msb_first,
    input  logic          sync_mode,
    input  logic          clr_err,
    input  logic          rd_stb,
    input  logic          brk_det,
    input  logic          rie,
    output logic [DW-1:0] rdata,
    output logic          flag_par,
    output logic          flag_lost,
    output logic          flag_stop,
    output logic          flag_ready,
    output logic          irq
);
    logic          rx_s;
    logic [DW-1:0] frm_word;
    logic          frm_pbad;
    logic          frm_sbad;
    logic          frm_done;
    logic          eff_msb;
    rx_flags_t     flags;

    assign eff_msb = msb_first & ~sync_mode;

    srx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
    );

    srx_framer #(.DW(DW)) u_framer (
        .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
        .par_en(par_en), .two_stop(two_stop), .msb(eff_msb),
        .word(frm_word), .par_bad(frm_pbad), .stop_bad(frm_sbad),
        .done(frm_done)
    );

    srx_status #(.DW(DW)) u_status (
        .clk(clk), .rst(rst), .done(frm_done), .word(frm_word),
        .par_bad(frm_pbad), .stop_bad(frm_sbad), .clr_err(clr_err),
        .rd_stb(rd_stb), .brk_det(brk_det), .hold(rdata), .flags(flags)
    );

    assign flag_par   = flags.par;
    assign flag_lost  = flags.lost;
    assign flag_stop  = flags.stop;
    assign flag_ready = flags.ready;
    assign irq        = rie & any_flag(flags);
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          brk_det,
    input logic          clr_err,
    input logic          rd_stb,
    input logic          done,
    input logic          rie,
    input logic          irq,
    input logic          par_en,
    input logic          flag_par,
    input logic          flag_lost,
    input logic          flag_stop,
    input logic          flag_ready,
    input logic [DW-1:0] rdata
);
    AST_BRK_WIPES: assert property (@(posedge clk) disable iff (rst)
        brk_det |=> !flag_par && !flag_lost && !flag_stop && !flag_ready); // R10
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_err |=> !flag_par && !flag_lost && !flag_stop); // R9
    AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        flag_ready && !rd_stb |=> $stable(rdata)); // R8
    AST_LOST_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_lost) |-> $past(flag_ready)); // R8
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !done |=> !flag_ready); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !rie |-> !irq); // R11
    AST_PAR_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_par) |-> $past(par_en)); // R5
endmodule

bind serial_rx_flags srx_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .brk_det(brk_det), .clr_err(clr_err),
    .rd_stb(rd_stb), .done(frm_done), .rie(rie), .irq(irq),
    .par_en(par_en), .flag_par(flag_par), .flag_lost(flag_lost),
    .flag_stop(flag_stop), .flag_ready(flag_ready), .rdata(rdata)
);

// File: tb/serial_rx_flags_tb.sv
`timescale 1ns/1ps
module serial_rx_flags_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0, two_stop = 1'b0, msb_first = 1'b0, sync_mode = 1'b0;
    logic       clr_err = 1'b0, rd_stb = 1'b0, brk_det = 1'b0, rie = 1'b0;
    logic [7:0] rdata;
    logic       flag_par, flag_lost, flag_stop, flag_ready, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_rx_flags u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .par_en(par_en), .two_stop(two_stop), .msb_first(msb_first),
        .sync_mode(sync_mode), .clr_err(clr_err), .rd_stb(rd_stb),
        .brk_det(brk_det), .rie(rie), .rdata(rdata), .flag_par(flag_par),
        .flag_lost(flag_lost), .flag_stop(flag_stop), .flag_ready(flag_ready),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] w, input logic flip_par,
                              input logic s1_low, input logic s2_low);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(w[i]);
        if (par_en) hold_bit((^w) ^ flip_par);
        hold_bit(~s1_low);
        if (two_stop) hold_bit(~s2_low);
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_brk();
        brk_det = 1'b1; @(negedge clk); brk_det = 1'b0; @(negedge clk);
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic t_reset();
        check("R1 flags", {flag_par, flag_lost, flag_stop, flag_ready}, 4'h0);
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_order();
        send_frame(8'h1D, 0, 0, 0);
        check("R2 lsb-first word", rdata, 8'h1D);
        check("R7 ready set", flag_ready, 1'b1);
        check("R5 no parity flag when disabled", flag_par, 1'b0);
        pulse_rd();
        check("R7 read clears ready", flag_ready, 1'b0);
        msb_first = 1'b1;
        send_frame(8'h1D, 0, 0, 0);
        check("R2 msb-first word", rdata, rev8(8'h1D));
        pulse_rd();
        sync_mode = 1'b1;
        send_frame(8'h1D, 0, 0, 0);
        check("R3 mode forces lsb-first", rdata, 8'h1D);
        pulse_rd();
        sync_mode = 1'b0;
        msb_first = 1'b0;
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R4 short low ignored", flag_ready, 1'b0);
    endtask

    task automatic t_parity();
        par_en = 1'b1;
        send_frame(8'h6B, 0, 0, 0);
        check("R5 good parity", flag_par, 1'b0);
        check("R5 word with parity", rdata, 8'h6B);
        pulse_rd();
        send_frame(8'h6B, 1, 0, 0);
        check("R5 bad parity", flag_par, 1'b1);
        pulse_clr();
        check("R9 clear parity", flag_par, 1'b0);
        pulse_rd();
        clr_err = 1'b1;
        send_frame(8'h33, 1, 0, 0);
        clr_err = 1'b0;
        @(negedge clk);
        check("R9 clear wins over parity set", flag_par, 1'b0);
        pulse_rd();
        par_en = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h55, 0, 1, 0);
        check("R6 one stop low", flag_stop, 1'b1);
        pulse_clr(); pulse_rd();
        check("R9 clear stop flag", flag_stop, 1'b0);
        two_stop = 1'b1;
        send_frame(8'h55, 0, 0, 1);
        check("R6 second stop low", flag_stop, 1'b1);
        pulse_clr(); pulse_rd();
        send_frame(8'h55, 0, 1, 0);
        check("R6 first of two stop low", flag_stop, 1'b1);
        pulse_clr(); pulse_rd();
        send_frame(8'h55, 0, 0, 0);
        check("R6 clean two stop", flag_stop, 1'b0);
        pulse_rd();
        two_stop = 1'b0;
    endtask

    task automatic t_overrun();
        send_frame(8'hA1, 0, 0, 0);
        send_frame(8'h5E, 0, 0, 0);
        check("R8 overrun flag", flag_lost, 1'b1);
        check("R8 old word kept", rdata, 8'hA1);
        pulse_clr();
        check("R9 clear overrun", flag_lost, 1'b0);
        check("R7 clear leaves ready", flag_ready, 1'b1);
        pulse_rd();
    endtask

    task automatic t_break_irq();
        par_en = 1'b1;
        send_frame(8'hC4, 1, 0, 0);
        check("R11 irq masked", irq, 1'b0);
        rie = 1'b1;
        @(negedge clk);
        check("R11 irq on flags", irq, 1'b1);
        pulse_brk();
        check("R10 break wipes flags", {flag_par, flag_lost, flag_stop, flag_ready}, 4'h0);
        check("R11 irq drops", irq, 1'b0);
        brk_det = 1'b1;
        send_frame(8'h0F, 1, 0, 0);
        brk_det = 1'b0;
        @(negedge clk);
        check("R10 break wins over set", {flag_par, flag_ready}, 2'b00);
        par_en = 1'b0;
        rie = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_glitch();
        t_parity();
        t_framing();
        t_overrun();
        t_break_irq();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule